// File: doc/BRIEF.md
# Lazy Page Eviction Writer for a DRAM-Cached Phase-Change Memory

This block sits between a DRAM page cache and a slower, wear-limited phase-change background memory. The cache controller hands it an eviction request. The request carries the page number, a flag saying whether the background memory already holds a valid copy of the page, and a 16-bit mask of the page's dirty lines. A page is 4 KB and a line is 256 B, so a page holds 16 lines.

The block writes back lazily. Filling a page from disk never reaches the background memory, and writes happen only when a page leaves DRAM. If the background copy is missing, all 16 lines are written. If the copy exists, only the dirty lines are written. A page with a valid copy and no dirty lines is released with no writes at all.

Each page carries a 4-bit rotation value. A logical line is stored at a physical slot within the page that is offset by this value, so repeated write-backs of the same page spread wear across its slots. Writes go out one at a time over a valid/ready port. The line data comes from a combinational read port into the DRAM cache.

Top module: `page_evict_writer`

## Requirements
- R1: `ev_ready` is 1 while the block is idle. It is 0 from the cycle after an eviction is accepted (`ev_valid` and `ev_ready` both high at a rising edge) through the cycle in which `ev_done` is high.
- R2: When `ev_present` is 0, all 16 logical lines are written once each, in ascending logical order 0..15, whatever `ev_dirty` holds.
- R3: When `ev_present` is 1, exactly the logical lines whose bit is set in `ev_dirty` are written (bit i stands for logical line i), in ascending logical order.
- R4: When `ev_present` is 1 and `ev_dirty` is 0, no write is issued. `ev_done` is high in the cycle right after acceptance, and `pres_set` stays 0.
- R5: Logical line i of a page is written to `wr_slot` = (i + rot) mod 16. Here rot is the page's rotation value at the moment the eviction is accepted.
- R6: A page's rotation value starts at 0 and increases by 1 (mod 16) after each eviction of that page that issued at least one write. An eviction with no writes leaves it unchanged. Other pages are unaffected.
- R7: A write stays asserted with stable `wr_page`, `wr_slot` and `wr_data` until `wr_ready` is high at a rising edge. `wr_data` equals the read-port data for `rd_page`/`rd_line`, where `rd_line` is the logical line being written.
- R8: `ev_done` is a single-cycle pulse in the cycle after the last write handshake, with `done_page` showing the evicted page. `pres_set` is high with it exactly when at least one write was issued, which marks the background copy as present.
- R9: No write is issued unless an eviction has been accepted. An idle block with `ev_valid` low keeps `wr_valid` low.
- R10: An `ev_valid` raised while an eviction is in progress is ignored. It does not change the ongoing write sequence and does not start a further eviction.
- R11: A synchronous active-high `rst` returns the block to idle and clears every page's rotation value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Eviction request valid |
| ev_ready | output | 1 | Block idle and able to accept a request |
| ev_page | input | PAGE_W | Page being evicted |
| ev_present | input | 1 | Background memory already holds a valid copy |
| ev_dirty | input | 16 | Dirty mask, bit i = logical line i |
| ev_done | output | 1 | One-cycle completion pulse |
| pres_set | output | 1 | With `ev_done`: background copy is now present |
| done_page | output | PAGE_W | Page the completion refers to |
| rd_req | output | 1 | Read of a cache line is in use |
| rd_page | output | PAGE_W | Page read from the DRAM cache |
| rd_line | output | 4 | Logical line read from the DRAM cache |
| rd_data | input | DATA_W | Line data from the DRAM cache (combinational) |
| wr_valid | output | 1 | Background-memory line write valid |
| wr_ready | input | 1 | Background memory takes the write |
| wr_page | output | PAGE_W | Page of the line write |
| wr_slot | output | 4 | Rotated physical slot within the page |
| wr_data | output | DATA_W | Line data being written |

## Verification
The main function is exercised with four kinds of request. Absent-copy requests with arbitrary dirty masks show that the mask is ignored when a full write is needed. Present-copy requests with sparse masks, including the lowest and highest lines only, show that the partial-write filter and the ascending order are correct. Clean present-copy requests separate the no-write path from a zero-length write sequence. Seventeen back-to-back write-backs of one page walk the rotation through its 15-to-0 wrap, and a mid-run reset shows the rotation table clearing. Random stalls on `wr_ready` and stray requests raised during busy periods separate correct holding from dropped or repeated lines.

// File: rtl/pew_pkg.sv
package pew_pkg;

    localparam int LINES_PER_PAGE = 16;
    localparam int LINE_IDX_W     = $clog2(LINES_PER_PAGE);

    typedef logic [LINE_IDX_W-1:0]     line_idx_t;
    typedef logic [LINES_PER_PAGE-1:0] line_mask_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } evict_state_e;

    typedef struct packed {
        line_mask_t pend;    // lines still to be written
        line_idx_t  rot;     // rotation captured at acceptance
        logic       wrote;   // at least one write was owed
    } evict_job_t;

    // physical slot for a logical line, wrapping within the page
    function automatic line_idx_t rot_slot(input line_idx_t line, input line_idx_t rot);
        return line_idx_t'(line + rot);
    endfunction

    // lowest set bit of a line mask (0 when empty)
    function automatic line_idx_t lowest_line(input line_mask_t m);
        line_idx_t r;
        r = '0;
        for (int i = LINES_PER_PAGE - 1; i >= 0; i--) begin
            if (m[i]) r = line_idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pew_rot_table.sv
module pew_rot_table
    import pew_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] rd_page,
    output line_idx_t         rd_rot,
    input  logic              inc_en,
    input  logic [PAGE_W-1:0] inc_page
);
    localparam int NUM_PAGES = 1 << PAGE_W;

    line_idx_t rot_q [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                rot_q[g] <= '0;
            end else if (inc_en && (inc_page == PAGE_W'(g))) begin
                rot_q[g] <= line_idx_t'(rot_q[g] + 1'b1);
            end
        end
    end

    assign rd_rot = rot_q[rd_page];

endmodule

// File: rtl/pew_line_pick.sv
module pew_line_pick
    import pew_pkg::*;
(
    input  line_mask_t pend,
    output logic       any,
    output line_idx_t  line
);
    assign any  = |pend;
    assign line = lowest_line(pend);
endmodule

// File: rtl/page_evict_writer.sv
module page_evict_writer
    import pew_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ev_valid,
    output logic                      ev_ready,
    input  logic [PAGE_W-1:0]         ev_page,
    input  logic                      ev_present,
    input  logic [LINES_PER_PAGE-1:0] ev_dirty,
    output logic                      ev_done,
    output logic                      pres_set,
    output logic [PAGE_W-1:0]         done_page,
    output logic                      rd_req,
    output logic [PAGE_W-1:0]         rd_page,
    output logic [LINE_IDX_W-1:0]     rd_line,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [PAGE_W-1:0]         wr_page,
    output logic [LINE_IDX_W-1:0]     wr_slot,
    output logic [DATA_W-1:0]         wr_data
);
    evict_state_e      state_q;
    evict_job_t        job_q;
    logic [PAGE_W-1:0] page_q;
    line_idx_t         rot_now;
    line_idx_t         cur_line;
    logic              pend_any;
    line_mask_t        need_mask;
    logic              inc_en;

    pew_rot_table #(.PAGE_W(PAGE_W)) u_rot (
        .clk      (clk),
        .rst      (rst),
        .rd_page  (ev_page),
        .rd_rot   (rot_now),
        .inc_en   (inc_en),
        .inc_page (page_q)
    );

    pew_line_pick u_pick (
        .pend (job_q.pend),
        .any  (pend_any),
        .line (cur_line)
    );

    // absent copy: whole page; present copy: dirty lines only
    assign need_mask = ev_present ? line_mask_t'(ev_dirty) : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            page_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ev_valid) begin
                        state_q     <= ST_BUSY;
                        page_q      <= ev_page;
                        job_q.pend  <= need_mask;
                        job_q.rot   <= rot_now;
                        job_q.wrote <= |need_mask;
                    end
                end
                ST_BUSY: begin
                    if (!pend_any) begin
                        state_q <= ST_IDLE;
                    end else if (wr_ready) begin
                        job_q.pend <= job_q.pend & ~(line_mask_t'(1) << cur_line);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ev_ready  = (state_q == ST_IDLE);
    assign wr_valid  = (state_q == ST_BUSY) && pend_any;
    assign ev_done   = (state_q == ST_BUSY) && !pend_any;
    assign pres_set  = ev_done && job_q.wrote;
    assign inc_en    = ev_done && job_q.wrote;
    assign done_page = page_q;

    assign rd_req    = wr_valid;
    assign rd_page   = page_q;
    assign rd_line   = cur_line;

    assign wr_page   = page_q;
    assign wr_slot   = rot_slot(cur_line, job_q.rot);
    assign wr_data   = rd_data;

endmodule

// File: rtl/pew_chk.sv
module pew_chk #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              ev_present,
    input logic [15:0]       ev_dirty,
    input logic              ev_done,
    input logic              pres_set,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [PAGE_W-1:0] wr_page,
    input logic [3:0]        wr_slot,
    input logic [DATA_W-1:0] wr_data
);
    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !ev_ready);

    // R1
    done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> !ev_ready);

    // R4
    clean_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready && ev_present && (ev_dirty == 16'h0)) |=> (ev_done && !wr_valid && !pres_set));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_slot) && $stable(wr_page) && $stable(wr_data)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> !ev_done);

    // R8
    pres_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        pres_set |-> ev_done);

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_ready && !ev_valid) |=> !wr_valid);

endmodule

bind page_evict_writer pew_chk #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_present (ev_present),
    .ev_dirty   (ev_dirty),
    .ev_done    (ev_done),
    .pres_set   (pres_set),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_page    (wr_page),
    .wr_slot    (wr_slot),
    .wr_data    (wr_data)
);

// File: tb/sim_page_evict_writer.sv
module sim_page_evict_writer;
    localparam int PW = 4;
    localparam int DW = 64;
    localparam int NP = 1 << PW;

    logic          clk = 1'b0;
    logic          rst;
    logic          ev_valid;
    logic          ev_ready;
    logic [PW-1:0] ev_page;
    logic          ev_present;
    logic [15:0]   ev_dirty;
    logic          ev_done;
    logic          pres_set;
    logic [PW-1:0] done_page;
    logic          rd_req;
    logic [PW-1:0] rd_page;
    logic [3:0]    rd_line;
    logic [DW-1:0] rd_data;
    logic          wr_valid;
    logic          wr_ready;
    logic [PW-1:0] wr_page;
    logic [3:0]    wr_slot;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int model_rot [NP];

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [DW-1:0] line_word(input logic [PW-1:0] p, input logic [3:0] l);
        return (64'(p) * 64'h0001_0003_0005_0007) ^ (64'(l) * 64'h0100_0000_0000_0011) ^ 64'hA5A5_0000_5A5A_0000;
    endfunction

    assign rd_data = line_word(rd_page, rd_line);

    page_evict_writer #(.PAGE_W(PW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_page(ev_page),
        .ev_present(ev_present), .ev_dirty(ev_dirty),
        .ev_done(ev_done), .pres_set(pres_set), .done_page(done_page),
        .rd_req(rd_req), .rd_page(rd_page), .rd_line(rd_line), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_page(wr_page),
        .wr_slot(wr_slot), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    // one eviction; poke raises ev_valid during the busy period (R10)
    task automatic evict(input logic [PW-1:0] pg, input bit p, input logic [15:0] dm, input bit poke);
        logic [15:0] rem;
        int          rot;
        int          guard;
        int          ln;
        int          gap;
        rem   = p ? dm : 16'hFFFF;
        rot   = model_rot[pg];
        guard = 0;
        gap   = 0;
        @(negedge clk);
        chk(ev_ready == 1'b1, "R1 ready when idle", 64'(ev_ready), 64'd1);
        ev_valid = 1'b1; ev_page = pg; ev_present = p; ev_dirty = dm;
        @(negedge clk);
        ev_valid = 1'b0;
        ev_page = ~pg; ev_dirty = ~dm; ev_present = ~p;
        forever begin
            guard++;
            if (guard > 200) begin
                chk(1'b0, "R8 eviction finishes", 64'(guard), 64'd200);
                break;
            end
            chk(ev_ready == 1'b0, "R1 not ready while busy", 64'(ev_ready), 64'd0);
            if (ev_done) begin
                ev_valid = 1'b0;
                wr_ready = 1'b0;
                chk(rem == 16'h0, "R2 R3 all owed lines written", 64'(rem), 64'd0);
                chk(wr_valid == 1'b0, "R8 no write with done", 64'(wr_valid), 64'd0);
                chk(pres_set == ((p ? dm : 16'hFFFF) != 16'h0), "R8 pres_set", 64'(pres_set),
                    64'((p ? dm : 16'hFFFF) != 16'h0));
                chk(done_page == pg, "R8 done_page", 64'(done_page), 64'(pg));
                if (p && dm == 16'h0)
                    chk(guard == 1, "R4 clean done right after accept", 64'(guard), 64'd1);
                if ((p ? dm : 16'hFFFF) != 16'h0) model_rot[pg] = (model_rot[pg] + 1) % 16;
                break;
            end
            if (wr_valid) begin
                ln = lowest(rem);
                if (ln < 0) begin
                    chk(1'b0, "R3 extra write", 64'(wr_slot), 64'hFFFF);
                    wr_ready = 1'b1;
                end else begin
                    chk(rd_line == 4'(ln), p ? "R3 dirty line order" : "R2 full page order", 64'(rd_line), 64'(ln));
                    chk(wr_slot == 4'((ln + rot) % 16), "R5 rotated slot", 64'(wr_slot), 64'((ln + rot) % 16));
                    chk(wr_page == pg, "R7 write page", 64'(wr_page), 64'(pg));
                    chk(wr_data == line_word(pg, 4'(ln)), "R7 write data", wr_data, line_word(pg, 4'(ln)));
                    if (($urandom % 3) == 0) begin
                        wr_ready = 1'b0;
                    end else begin
                        wr_ready = 1'b1;
                        rem[ln] = 1'b0;
                    end
                end
            end else begin
                wr_ready = 1'b0;
                gap++;
                chk(gap < 2, "R8 no idle gap in busy", 64'(gap), 64'd1);
            end
            if (poke) begin
                ev_valid = 1'b1; ev_page = pg + 1'b1; ev_present = 1'b0; ev_dirty = 16'hFFFF;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(wr_valid == 1'b0, "R9 R10 no write without accepted eviction", 64'(wr_valid), 64'd0);
            chk(ev_done == 1'b0, "R10 no extra completion", 64'(ev_done), 64'd0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) model_rot[i] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20110419));
        ev_valid = 1'b0; ev_page = '0; ev_present = 1'b0; ev_dirty = '0; wr_ready = 1'b0;
        do_reset();
        @(negedge clk);
        chk(ev_ready == 1'b1, "R11 idle after reset", 64'(ev_ready), 64'd1);
        chk(wr_valid == 1'b0, "R11 no write after reset", 64'(wr_valid), 64'd0);
        chk(ev_done == 1'b0, "R11 no done after reset", 64'(ev_done), 64'd0);
        idle_quiet(5);

        // R2: absent copy, dirty mask ignored
        evict(4'd3, 1'b0, 16'h0000, 1'b0);
        evict(4'd3, 1'b0, 16'h0420, 1'b0);
        // R4: present and clean, rotation unchanged
        evict(4'd3, 1'b1, 16'h0000, 1'b0);
        // R3: lowest and highest lines only
        evict(4'd3, 1'b1, 16'h8001, 1'b0);
        // R6: rotation wrap on one page
        for (int k = 0; k < 17; k++) evict(4'd5, 1'b1, 16'h0001, 1'b0);
        // R10: stray requests during busy
        evict(4'd7, 1'b1, 16'h5A5A, 1'b1);
        idle_quiet(3);
        evict(4'd7, 1'b0, 16'h0000, 1'b1);
        idle_quiet(3);

        // R11: reset clears rotations
        do_reset();
        evict(4'd5, 1'b1, 16'h0002, 1'b0);
        evict(4'd3, 1'b1, 16'hFFFF, 1'b0);

        for (int k = 0; k < 60; k++) begin
            logic [15:0] dm;
            dm = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
            evict(4'($urandom % NP), 1'($urandom % 2), dm, 1'($urandom % 2));
        end
        idle_quiet(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule